// File: doc/BRIEF.md
# Converter Output Test Pattern Generator

This block sits between the sample data path of a converter and its output pins. With the test mode field at zero, it passes the live sample through. Before that, it adds a signed trim to the sample and clamps the sum to the legal code range. A nonzero test mode replaces the sample with synthetic data. The synthetic sources are:

- fixed levels;
- an alternating bit pattern;
- an all-ones/all-zeros word toggle;
- two pseudo-random sequences;
- a user sequence that rotates through two programmable words and zero.

Each pseudo-random generator has its own hold-in-reset control. All test values are defined in the offset-binary domain. A final stage converts every word, live or synthetic, to the chosen number format and can invert it. The output is registered, and all configuration fields are plain inputs driven by a register file elsewhere.

Top module: `adc_tpg`

## Requirements
- R1: With `test_mode` = 0 and `trim` = 0, `dout` is the `live_in` value of the previous clock.
- R2: In live modes, `live_in` plus the two's-complement `trim` is clamped to the range 0 to 2^W-1 rather than wrapping.
- R3: Mode 1 gives 0x80, mode 2 gives 0xFF and mode 3 gives 0x00.
- R4: Mode 4 alternates 0x55 and 0xAA, starting with 0x55 on the first sample after reset. Mode 7 alternates 0xFF and 0x00, starting with 0xFF. Both use a phase bit that flips on every clock.
- R5: Mode 5 outputs the low 8 bits of a 9-bit generator. Each clock it steps as s <= {s[7:0], s[8]^s[4]}, and it is seeded to all ones.
- R6: Mode 6 outputs the low 8 bits of a 23-bit generator that steps as s <= {s[21:0], s[22]^s[17]}, and it is seeded to all ones.
- R7: While `pn9_hold` or `pn23_hold` is 1, the matching generator is held at all ones. After release it restarts from that seed. Both generators run in every mode.
- R8: Codes 9 through 15 behave exactly like mode 0, including the trim.
- R9: In mode 8, `usr_order` chooses the rotation:
  - 0 gives `pat1` only;
  - 1 alternates `pat1` and `pat2`;
  - 2 alternates `pat1` and zero;
  - 3 cycles `pat1`, `pat2`, zero.

  A sample in which `test_mode` or `usr_order` differs from the previous sample restarts the rotation at `pat1`.
- R10: `fmt_sel` selects the output format:
  - 0 gives offset binary (no change);
  - 1 gives two's complement (MSB inverted);
  - 2 gives Gray code (x ^ (x >> 1));
  - 3 acts as 0.
- R11: `out_inv` = 1 inverts every bit of the formatted word.
- R12: Synchronous `rst` clears `dout` to 0, seeds both generators, zeroes the phase and rotation position, and clears the stored previous mode and order. Every output appears one clock after its inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| live_in | input | 8 | Live converter sample, offset binary |
| test_mode | input | 4 | Test source select |
| usr_order | input | 2 | User pattern rotation order |
| pn9_hold | input | 1 | Hold 9-bit generator at its seed |
| pn23_hold | input | 1 | Hold 23-bit generator at its seed |
| pat1 | input | 8 | First user word |
| pat2 | input | 8 | Second user word |
| fmt_sel | input | 2 | Output number format |
| out_inv | input | 1 | Invert formatted output |
| trim | input | 8 | Signed offset added to live samples |
| dout | output | 8 | Registered output word |

## Verification
The bench checks live samples at low, middle and high codes. This separates plain pass-through from the trim path, and the trim is driven at both range ends to show clamping rather than wrapping. Both pseudo-random generators are checked against long runs that include hold and release, which exposes wrong taps, a wrong seed or a wrong phase after release. The user rotation is tried in all four orders, with order and mode changes in the middle of a run, to separate correct restart from a sequence that simply keeps counting. Each output format is applied to both live and generated words, with and without inversion, so a wrong bit mapping cannot hide behind a symmetric pattern.

// File: rtl/tpg_pkg.sv
package tpg_pkg;
   localparam logic [3:0] TM_OFF  = 4'h0;
   localparam logic [3:0] TM_MID  = 4'h1;
   localparam logic [3:0] TM_PFS  = 4'h2;
   localparam logic [3:0] TM_NFS  = 4'h3;
   localparam logic [3:0] TM_CHK  = 4'h4;
   localparam logic [3:0] TM_PN9  = 4'h5;
   localparam logic [3:0] TM_PN23 = 4'h6;
   localparam logic [3:0] TM_TOG  = 4'h7;
   localparam logic [3:0] TM_USER = 4'h8;

   typedef enum logic [1:0] {
      FMT_OFFBIN = 2'd0,
      FMT_TWOS   = 2'd1,
      FMT_GRAY   = 2'd2,
      FMT_RSVD   = 2'd3
   } fmt_e;

   typedef enum logic [1:0] {
      POS_P1   = 2'd0,
      POS_P2   = 2'd1,
      POS_ZERO = 2'd2,
      POS_BAD  = 2'd3
   } upos_e;
endpackage

// File: rtl/tpg_prbs.sv
module tpg_prbs #(
   parameter int LEN   = 9,
   parameter int TAP   = 5,
   parameter int OUT_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             hold,
   output logic [OUT_W-1:0] word
);
   localparam logic [LEN-1:0] SEED = '1;

   if (TAP >= LEN || TAP < 1) begin : g_bad_tap
      $error("tpg_prbs: TAP must lie in 1..LEN-1");
   end
   if (OUT_W > LEN) begin : g_bad_width
      $error("tpg_prbs: OUT_W exceeds register length");
   end

   logic [LEN-1:0] st;
   logic           fb;

   assign fb = st[LEN-1] ^ st[TAP-1];

   always_ff @(posedge clk) begin
      if (rst || hold) st <= SEED;
      else             st <= {st[LEN-2:0], fb};
   end

   assign word = st[OUT_W-1:0];

   assert_pn_nonzero_R5: assert property (@(posedge clk) disable iff (rst)
      st != '0);
   assert_hold_seed_R7: assert property (@(posedge clk) disable iff (rst)
      hold |=> word == '1);
endmodule

// File: rtl/tpg_user_seq.sv
module tpg_user_seq
   import tpg_pkg::*;
#(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [3:0]   tmode,
   input  logic [1:0]   order,
   input  logic [W-1:0] p1,
   input  logic [W-1:0] p2,
   output logic [W-1:0] pat
);
   logic [3:0] tmode_q;
   logic [1:0] order_q;
   upos_e      pos_q, pos_eff, pos_nxt;
   logic       act, restart;

   assign act     = (tmode == TM_USER);
   assign restart = (tmode != tmode_q) || (order != order_q);
   assign pos_eff = restart ? POS_P1 : pos_q;

   always_comb begin
      pos_nxt = POS_P1;
      unique case (order)
         2'd0: pos_nxt = POS_P1;
         2'd1: pos_nxt = (pos_eff == POS_P1) ? POS_P2 : POS_P1;
         2'd2: pos_nxt = (pos_eff == POS_P1) ? POS_ZERO : POS_P1;
         2'd3: pos_nxt = (pos_eff == POS_P1) ? POS_P2 :
                         (pos_eff == POS_P2) ? POS_ZERO : POS_P1;
         default: pos_nxt = POS_P1;
      endcase
   end

   always_comb begin
      unique case (pos_eff)
         POS_P1:  pat = p1;
         POS_P2:  pat = p2;
         default: pat = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         pos_q   <= POS_P1;
         tmode_q <= TM_OFF;
         order_q <= 2'd0;
      end else begin
         pos_q   <= act ? pos_nxt : POS_P1;
         tmode_q <= tmode;
         order_q <= order;
      end
   end

   assert_pos_legal_R9: assert property (@(posedge clk) disable iff (rst)
      pos_q != POS_BAD);
   assert_idle_pos_R9: assert property (@(posedge clk) disable iff (rst)
      !act |=> pos_q == POS_P1);
   assert_single_order_R9: assert property (@(posedge clk) disable iff (rst)
      (act && order == 2'd0) |=> pos_q == POS_P1);
endmodule

// File: rtl/tpg_fmt.sv
module tpg_fmt
   import tpg_pkg::*;
#(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] din,
   input  logic [1:0]   fmt,
   input  logic         inv,
   output logic [W-1:0] dout
);
   logic [W-1:0] gray;
   logic [W-1:0] shaped;
   fmt_e         sel;

   assign sel = fmt_e'(fmt);

   assign gray[W-1] = din[W-1];
   for (genvar i = 0; i < W-1; i++) begin : g_gray
      assign gray[i] = din[i+1] ^ din[i];
   end

   always_comb begin
      unique case (sel)
         FMT_TWOS: shaped = {~din[W-1], din[W-2:0]};
         FMT_GRAY: shaped = gray;
         default:  shaped = din;
      endcase
   end

   assign dout = inv ? ~shaped : shaped;

   assert_twos_msb_R10: assert property (@(posedge clk) disable iff (rst)
      (sel == FMT_TWOS && !inv) |-> dout[W-1] != din[W-1]);
   assert_gray_msb_R10: assert property (@(posedge clk) disable iff (rst)
      (sel == FMT_GRAY && !inv) |-> dout[W-1] == din[W-1]);
   assert_inv_lsbs_R11: assert property (@(posedge clk) disable iff (rst)
      (sel == FMT_OFFBIN && inv) |-> (dout ^ din) == '1);
endmodule

// File: rtl/adc_tpg.sv
module adc_tpg
   import tpg_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int PNA_LEN  = 9,
   parameter int PNA_TAP  = 5,
   parameter int PNB_LEN  = 23,
   parameter int PNB_TAP  = 18
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [DATA_W-1:0] live_in,
   input  logic [3:0]        test_mode,
   input  logic [1:0]        usr_order,
   input  logic              pn9_hold,
   input  logic              pn23_hold,
   input  logic [DATA_W-1:0] pat1,
   input  logic [DATA_W-1:0] pat2,
   input  logic [1:0]        fmt_sel,
   input  logic              out_inv,
   input  logic [DATA_W-1:0] trim,
   output logic [DATA_W-1:0] dout
);
   localparam int SUM_W = DATA_W + 2;
   localparam logic [DATA_W-1:0] MIDSCALE = {1'b1, {(DATA_W-1){1'b0}}};
   localparam logic [DATA_W-1:0] FULL_POS = '1;
   localparam logic [DATA_W-1:0] FULL_NEG = '0;
   localparam logic [SUM_W-1:0]  CODE_MAX = {2'b00, {DATA_W{1'b1}}};

   if (DATA_W < 4) begin : g_bad_w
      $error("adc_tpg: DATA_W must be at least 4");
   end

   function automatic logic [DATA_W-1:0] checker_word(input logic odd);
      logic [DATA_W-1:0] w;
      for (int i = 0; i < DATA_W; i++) w[i] = odd ? (i % 2 == 1) : (i % 2 == 0);
      return w;
   endfunction

   localparam logic [DATA_W-1:0] CHK_A = checker_word(1'b0);
   localparam logic [DATA_W-1:0] CHK_B = checker_word(1'b1);

   // trimmed live sample, clamped to the code range
   logic signed [SUM_W-1:0] sum;
   logic [DATA_W-1:0]       adj;

   assign sum = $signed({2'b00, live_in}) + $signed({{2{trim[DATA_W-1]}}, trim});

   always_comb begin
      if (sum[SUM_W-1])                        adj = '0;
      else if ($unsigned(sum) > CODE_MAX)      adj = '1;
      else                                     adj = sum[DATA_W-1:0];
   end

   // pattern sources
   logic              phase;
   logic [DATA_W-1:0] pna_word, pnb_word, usr_word;

   always_ff @(posedge clk) begin
      if (rst) phase <= 1'b0;
      else     phase <= ~phase;
   end

   tpg_prbs #(.LEN(PNA_LEN), .TAP(PNA_TAP), .OUT_W(DATA_W)) u_pna (
      .clk (clk), .rst (rst), .hold (pn9_hold), .word (pna_word)
   );

   tpg_prbs #(.LEN(PNB_LEN), .TAP(PNB_TAP), .OUT_W(DATA_W)) u_pnb (
      .clk (clk), .rst (rst), .hold (pn23_hold), .word (pnb_word)
   );

   tpg_user_seq #(.W(DATA_W)) u_seq (
      .clk (clk), .rst (rst), .tmode (test_mode), .order (usr_order),
      .p1 (pat1), .p2 (pat2), .pat (usr_word)
   );

   logic [DATA_W-1:0] raw;

   always_comb begin
      unique case (test_mode)
         TM_MID:  raw = MIDSCALE;
         TM_PFS:  raw = FULL_POS;
         TM_NFS:  raw = FULL_NEG;
         TM_CHK:  raw = phase ? CHK_B : CHK_A;
         TM_PN9:  raw = pna_word;
         TM_PN23: raw = pnb_word;
         TM_TOG:  raw = phase ? FULL_NEG : FULL_POS;
         TM_USER: raw = usr_word;
         default: raw = adj;
      endcase
   end

   logic [DATA_W-1:0] shaped;

   tpg_fmt #(.W(DATA_W)) u_fmt (
      .clk (clk), .rst (rst), .din (raw), .fmt (fmt_sel), .inv (out_inv),
      .dout (shaped)
   );

   always_ff @(posedge clk) begin
      if (rst) dout <= '0;
      else     dout <= shaped;
   end

   assert_sat_up_R2: assert property (@(posedge clk) disable iff (rst)
      !trim[DATA_W-1] |-> adj >= live_in);
   assert_sat_dn_R2: assert property (@(posedge clk) disable iff (rst)
      trim[DATA_W-1] |-> adj <= live_in);
   assert_mid_level_R3: assert property (@(posedge clk) disable iff (rst)
      ($past(test_mode) == TM_MID && $past(fmt_sel) == 2'd0 && !$past(out_inv))
         |-> dout == MIDSCALE);
   assert_unused_live_R8: assert property (@(posedge clk) disable iff (rst)
      ($past(test_mode) > TM_USER && $past(fmt_sel) == 2'd0 && !$past(out_inv))
         |-> dout == $past(adj));
   assert_toggle_flip_R4: assert property (@(posedge clk) disable iff (rst)
      ($past(test_mode) == TM_TOG && test_mode == TM_TOG
         && $stable(fmt_sel) && $stable(out_inv)) |=> dout != $past(dout));
endmodule

// File: tb/adc_tpg_test.sv
`timescale 1ns/1ps
module adc_tpg_test;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [7:0] live_in = '0;
   logic [3:0] test_mode = '0;
   logic [1:0] usr_order = '0;
   logic       pn9_hold = 1'b0;
   logic       pn23_hold = 1'b0;
   logic [7:0] pat1 = '0;
   logic [7:0] pat2 = '0;
   logic [1:0] fmt_sel = '0;
   logic       out_inv = 1'b0;
   logic [7:0] trim = '0;
   logic [7:0] dout;

   int n_checks = 0;
   int n_fail   = 0;

   always #2.5 clk = ~clk;

   adc_tpg uut (
      .clk (clk), .rst (rst), .live_in (live_in), .test_mode (test_mode),
      .usr_order (usr_order), .pn9_hold (pn9_hold), .pn23_hold (pn23_hold),
      .pat1 (pat1), .pat2 (pat2), .fmt_sel (fmt_sel), .out_inv (out_inv),
      .trim (trim), .dout (dout)
   );

   // reference model state
   logic [8:0]  m_pn9  = '1;
   logic [22:0] m_pn23 = '1;
   logic        m_phase = 1'b0;
   int          m_pos = 0;
   logic [3:0]  m_pmode = '0;
   logic [1:0]  m_porder = '0;

   logic [7:0] exp_q[$];
   string      req_q[$];

   function automatic logic [7:0] clamp(input logic [7:0] x, input logic [7:0] t);
      int s;
      s = int'(x) + int'($signed(t));
      if (s < 0) return 8'h00;
      if (s > 255) return 8'hFF;
      return s[7:0];
   endfunction

   task automatic step(input string req);
      logic [7:0] r;
      int eff;
      int nxt;
      eff = (test_mode != m_pmode || usr_order != m_porder) ? 0 : m_pos;
      case (test_mode)
         4'd1: r = 8'h80;
         4'd2: r = 8'hFF;
         4'd3: r = 8'h00;
         4'd4: r = m_phase ? 8'hAA : 8'h55;
         4'd5: r = m_pn9[7:0];
         4'd6: r = m_pn23[7:0];
         4'd7: r = m_phase ? 8'h00 : 8'hFF;
         4'd8: r = (eff == 0) ? pat1 : (eff == 1) ? pat2 : 8'h00;
         default: r = clamp(live_in, trim);
      endcase
      if (fmt_sel == 2'd1) r = r ^ 8'h80;
      else if (fmt_sel == 2'd2) r = r ^ (r >> 1);
      if (out_inv) r = ~r;
      exp_q.push_back(r);
      req_q.push_back(req);
      case (usr_order)
         2'd0: nxt = 0;
         2'd1: nxt = (eff == 0) ? 1 : 0;
         2'd2: nxt = (eff == 0) ? 2 : 0;
         default: nxt = (eff == 0) ? 1 : (eff == 1) ? 2 : 0;
      endcase
      m_pos    = (test_mode == 4'd8) ? nxt : 0;
      m_pmode  = test_mode;
      m_porder = usr_order;
      m_pn9    = pn9_hold  ? 9'h1FF : {m_pn9[7:0], m_pn9[8] ^ m_pn9[4]};
      m_pn23   = pn23_hold ? 23'h7FFFFF : {m_pn23[21:0], m_pn23[22] ^ m_pn23[17]};
      m_phase  = ~m_phase;
      @(negedge clk);
   endtask

   // monitor: compares each produced word with the queued expectation
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (exp_q.size() > 0) begin
            logic [7:0] e;
            string      q;
            e = exp_q.pop_front();
            q = req_q.pop_front();
            n_checks++;
            if (dout !== e) begin
               n_fail++;
               $display("FAIL %s: dout=%02h expected=%02h", q, dout, e);
            end
         end
      end
   end

   initial begin
      #1000000;
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

   initial begin
      // R12: reset state
      repeat (3) @(negedge clk);
      n_checks++;
      if (dout !== 8'h00) begin
         n_fail++;
         $display("FAIL R12: dout=%02h expected=00 in reset", dout);
      end
      rst = 1'b0;

      // R1: pass-through
      live_in = 8'h12; step("R1");
      live_in = 8'h80; step("R1");
      live_in = 8'hFE; step("R1");
      live_in = 8'h00; step("R1");

      // R2: trim with clamping
      trim = 8'd10;  live_in = 8'd250; step("R2");
      live_in = 8'd100; step("R2");
      trim = 8'hEC;  live_in = 8'd5;   step("R2");
      live_in = 8'd200; step("R2");
      trim = 8'h7F;  live_in = 8'd128; step("R2");
      trim = 8'h80;  live_in = 8'd127; step("R2");
      trim = 8'h00;

      // R3: fixed levels
      test_mode = 4'd1; step("R3");
      test_mode = 4'd2; step("R3");
      test_mode = 4'd3; step("R3");

      // R4: checkerboard and word toggle
      test_mode = 4'd4;
      for (int i = 0; i < 4; i++) step("R4");
      test_mode = 4'd7;
      for (int i = 0; i < 4; i++) step("R4");

      // R5 / R6: generators
      test_mode = 4'd5;
      for (int i = 0; i < 20; i++) step("R5");
      test_mode = 4'd6;
      for (int i = 0; i < 30; i++) step("R6");

      // R7: hold controls
      test_mode = 4'd5; pn9_hold = 1'b1;
      for (int i = 0; i < 3; i++) step("R7");
      pn9_hold = 1'b0;
      for (int i = 0; i < 6; i++) step("R7");
      test_mode = 4'd6; pn23_hold = 1'b1;
      for (int i = 0; i < 3; i++) step("R7");
      pn23_hold = 1'b0;
      for (int i = 0; i < 6; i++) step("R7");

      // R8: unused codes equal live mode
      trim = 8'd3;
      for (int m = 9; m < 16; m++) begin
         test_mode = 4'(m);
         live_in = 8'(m * 17);
         step("R8");
      end
      trim = 8'h00;

      // R9: user rotations
      pat1 = 8'h3C; pat2 = 8'hC3; test_mode = 4'd8;
      usr_order = 2'd0; for (int i = 0; i < 3; i++) step("R9");
      usr_order = 2'd1; for (int i = 0; i < 4; i++) step("R9");
      usr_order = 2'd2; for (int i = 0; i < 4; i++) step("R9");
      usr_order = 2'd3; for (int i = 0; i < 5; i++) step("R9");
      usr_order = 2'd1; for (int i = 0; i < 3; i++) step("R9");
      test_mode = 4'd2; step("R9");
      test_mode = 4'd8; usr_order = 2'd3; for (int i = 0; i < 4; i++) step("R9");

      // R10: formats
      test_mode = 4'd0;
      fmt_sel = 2'd1; live_in = 8'h05; step("R10");
      live_in = 8'hC0; step("R10");
      test_mode = 4'd2; step("R10");
      fmt_sel = 2'd2; test_mode = 4'd0; live_in = 8'hB6; step("R10");
      test_mode = 4'd5; for (int i = 0; i < 4; i++) step("R10");
      fmt_sel = 2'd3; test_mode = 4'd0; live_in = 8'h9A; step("R10");

      // R11: inversion
      out_inv = 1'b1;
      fmt_sel = 2'd0; live_in = 8'h0F; step("R11");
      fmt_sel = 2'd1; test_mode = 4'd1; step("R11");
      fmt_sel = 2'd2; test_mode = 4'd4; step("R11"); step("R11");
      out_inv = 1'b0; fmt_sel = 2'd0; test_mode = 4'd0;

      // R12: one-cycle latency on a fast-changing input
      for (int i = 0; i < 6; i++) begin
         live_in = 8'(i * 41 + 7);
         step("R12");
      end

      repeat (3) @(negedge clk);
      if (exp_q.size() != 0) begin
         n_fail++;
         $display("FAIL R12: %0d results missing, expected 0", exp_q.size());
      end
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end
endmodule